// File: doc/BRIEF.md
# Dual-Rate Clock Enable Generator

This block sits in the oscillator clock domain of a small 8-bit microcontroller. From a single free-running phase counter it makes a CPU cycle-enable and a tick-enable for each of six peripherals: timer 0, timer 1, timer 2, the serial port, the counter array and the watchdog. Each enable is a one-clock pulse. Logic downstream qualifies its flops with the pulse, so no derived clock is ever built.

A control register on the special-function-register port picks the rates. It holds one global speed bit and one select bit per peripheral. With the global bit clear, every enable pulses once per 12 oscillator clocks. With the global bit set, the CPU pulses once every 6 clocks. Each peripheral then runs fast while its select bit is 0 and stays slow while its select bit is 1.

Rate changes take effect only at the end of a 12-clock frame. As a result, no pulse is ever shortened, moved early or doubled when the rate changes.

Top module: `dual_rate_ce`

## Requirements
- R1: Reset clears the whole control register and the phase counter. Reads return 0x00 after reset. The first CPU enable comes in the 12th clock after reset is released, and it repeats every 12 clocks while bit 0 is 0.
- R2: While bit 0 (the global speed bit) of the applied configuration is 1, the CPU enable pulses at frame phases 5 and 11, which is once every 6 clocks.
- R3: Register bits 1 to 6 select the rates of `periph_tick_en[0]` to `[5]` in this order: timer 0, timer 1, timer 2, serial port, counter array, watchdog.
- R4: While bit 0 is 0, every peripheral enable pulses only at phase 11, whatever its select bit holds.
- R5: While bit 0 is 1, a peripheral whose select bit is 0 pulses at phases 5 and 11. One whose select bit is 1 pulses only at phase 11.
- R6: The register sits at address 0x8F. A write strobe with that address loads the register on the next clock edge. Writes to any other address leave it unchanged. The read data shows the register while the address is 0x8F and shows 0 at any other address.
- R7: Bit 7 is reserved. It always reads 0, and writing it has no effect.
- R8: A new register value is applied only at the frame boundary, which is the edge that leaves phase 11. The frame in progress keeps its old rates to its end.
- R9: Every enable is high for exactly one clock per tick. At phase 11 all enables pulse together, and a peripheral never pulses without the CPU enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register port address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rd_data | output | 8 | Register read data (0 off-address) |
| cpu_cyc_en | output | 1 | CPU cycle enable pulse |
| periph_tick_en | output | 6 | Peripheral tick enables (timer0, timer1, timer2, serial, counter array, watchdog) |

## Verification
The bench builds the block with its default parameters: a 12-clock frame, a 6-clock fast point and six peripherals. With these values all 256 register values fit in one short run. Each value is written once and then observed for more than two full frames. The iteration length is not a multiple of 12, so writes land at every frame phase, which covers the deferral at the boundary. Interleaved writes to a neighbouring address check that off-address strobes are ignored and that the read port reads zero there.

// File: rtl/clk_en_pkg.sv
package clk_en_pkg;

    typedef enum logic {
        RATE_STD  = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

    function automatic rate_e periph_rate(input logic glob_fast, input logic sel_slow);
        return (glob_fast && !sel_slow) ? RATE_FAST : RATE_STD;
    endfunction

endpackage

// File: rtl/ce_ctl_reg.sv
module ce_ctl_reg #(
    parameter int          N_PERIPH = 6,
    parameter int          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h8F,
    localparam int         DATA_W   = N_PERIPH + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rd_data,
    output logic [N_PERIPH:0] ctl_bits
);

    typedef struct packed {
        logic [N_PERIPH:0] bits;
    } ctl_s;

    ctl_s ctl_d, ctl_q;
    logic hit;
    logic wdata_rsvd_unused;

    assign hit               = (sfr_addr == CTL_ADDR);
    assign wdata_rsvd_unused = sfr_wdata[DATA_W-1];

    always_comb begin
        ctl_d = ctl_q;
        if (sfr_wr && hit) begin
            ctl_d.bits = sfr_wdata[N_PERIPH:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl_bits    = ctl_q.bits;
    assign sfr_rd_data = hit ? {1'b0, ctl_q.bits} : '0;

endmodule

// File: rtl/ce_phase_gen.sv
module ce_phase_gen #(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 6,
    parameter int N_PERIPH = 6,
    localparam int PH_W    = $clog2(SLOW_DIV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PERIPH:0] ctl_bits,
    output logic              frame_end,
    output logic              fast_pt,
    output logic [N_PERIPH:0] eff_cfg
);

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [N_PERIPH:0] cfg;
    } st_s;

    st_s st_d, st_q;

    assign frame_end = (int'(st_q.phase) == SLOW_DIV - 1);
    assign fast_pt   = ((int'(st_q.phase) % FAST_DIV) == FAST_DIV - 1);

    always_comb begin
        st_d = st_q;
        if (frame_end) begin
            st_d.phase = '0;
            st_d.cfg   = ctl_bits;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eff_cfg = st_q.cfg;

endmodule

// File: rtl/ce_tick_decode.sv
module ce_tick_decode
    import clk_en_pkg::*;
#(
    parameter int N_PERIPH = 6
) (
    input  logic                frame_end,
    input  logic                fast_pt,
    input  logic [N_PERIPH:0]   eff_cfg,
    output logic                cpu_cyc_en,
    output logic [N_PERIPH-1:0] periph_tick_en
);

    rate_e cpu_rate;

    assign cpu_rate   = eff_cfg[0] ? RATE_FAST : RATE_STD;
    assign cpu_cyc_en = frame_end | ((cpu_rate == RATE_FAST) & fast_pt);

    for (genvar g = 0; g < N_PERIPH; g++) begin : g_periph
        rate_e p_rate;
        assign p_rate            = periph_rate(eff_cfg[0], eff_cfg[g+1]);
        assign periph_tick_en[g] = frame_end | ((p_rate == RATE_FAST) & fast_pt);
    end

endmodule

// File: rtl/dual_rate_ce.sv
module dual_rate_ce #(
    parameter int                N_PERIPH = 6,
    parameter int                SLOW_DIV = 12,
    parameter int                FAST_DIV = 6,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h8F,
    localparam int               DATA_W   = N_PERIPH + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   sfr_addr,
    input  logic                sfr_wr,
    input  logic [DATA_W-1:0]   sfr_wdata,
    output logic [DATA_W-1:0]   sfr_rd_data,
    output logic                cpu_cyc_en,
    output logic [N_PERIPH-1:0] periph_tick_en
);

    logic [N_PERIPH:0] ctl_bits;
    logic [N_PERIPH:0] eff_cfg;
    logic              frame_end;
    logic              fast_pt;

    ce_ctl_reg #(
        .N_PERIPH (N_PERIPH),
        .ADDR_W   (ADDR_W),
        .CTL_ADDR (CTL_ADDR)
    ) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .sfr_addr    (sfr_addr),
        .sfr_wr      (sfr_wr),
        .sfr_wdata   (sfr_wdata),
        .sfr_rd_data (sfr_rd_data),
        .ctl_bits    (ctl_bits)
    );

    ce_phase_gen #(
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV),
        .N_PERIPH (N_PERIPH)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_bits  (ctl_bits),
        .frame_end (frame_end),
        .fast_pt   (fast_pt),
        .eff_cfg   (eff_cfg)
    );

    ce_tick_decode #(
        .N_PERIPH (N_PERIPH)
    ) u_dec (
        .frame_end      (frame_end),
        .fast_pt        (fast_pt),
        .eff_cfg        (eff_cfg),
        .cpu_cyc_en     (cpu_cyc_en),
        .periph_tick_en (periph_tick_en)
    );

endmodule

// File: rtl/dual_rate_ce_chk.sv
module dual_rate_ce_chk #(
    parameter int                N_PERIPH = 6,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h8F
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   sfr_addr,
    input logic                sfr_wr,
    input logic [N_PERIPH+1:0] sfr_wdata,
    input logic [N_PERIPH+1:0] sfr_rd_data,
    input logic                cpu_cyc_en,
    input logic [N_PERIPH-1:0] periph_tick_en,
    input logic [N_PERIPH:0]   ctl_bits,
    input logic [N_PERIPH:0]   eff_cfg,
    input logic                frame_end
);

    a_r1_std_cpu_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cyc_en && !eff_cfg[0]) |-> frame_end);

    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == CTL_ADDR) |=> (ctl_bits == $past(sfr_wdata[N_PERIPH:0])));

    a_r7_rsvd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rd_data[N_PERIPH+1] == 1'b0);

    a_r8_cfg_held_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(eff_cfg));

    a_r9_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_cyc_en |=> !cpu_cyc_en);

    a_r9_periph_within_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (|periph_tick_en) |-> cpu_cyc_en);

endmodule

bind dual_rate_ce dual_rate_ce_chk #(
    .N_PERIPH (N_PERIPH),
    .ADDR_W   (ADDR_W),
    .CTL_ADDR (CTL_ADDR)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sfr_addr       (sfr_addr),
    .sfr_wr         (sfr_wr),
    .sfr_wdata      (sfr_wdata),
    .sfr_rd_data    (sfr_rd_data),
    .cpu_cyc_en     (cpu_cyc_en),
    .periph_tick_en (periph_tick_en),
    .ctl_bits       (ctl_bits),
    .eff_cfg        (eff_cfg),
    .frame_end      (frame_end)
);

// File: tb/test_dual_rate_ce.sv
`timescale 1ns/1ps
module test_dual_rate_ce;

    localparam int NP = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rd_data;
    logic       cpu_cyc_en;
    logic [NP-1:0] periph_tick_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] reg_m = 8'h00;
    logic [6:0] eff_m = 7'h00;

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    dual_rate_ce i_dual_rate_ce (
        .clk            (clk),
        .rst_n          (rst_n),
        .sfr_addr       (sfr_addr),
        .sfr_wr         (sfr_wr),
        .sfr_wdata      (sfr_wdata),
        .sfr_rd_data    (sfr_rd_data),
        .cpu_cyc_en     (cpu_cyc_en),
        .periph_tick_en (periph_tick_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Sample at negedge, check, apply boundary model, then drive next inputs.
    task automatic step(input logic wr, input logic [7:0] addr, input logic [7:0] data);
        int ph;
        logic exp_cpu;
        logic [NP-1:0] exp_p;
        @(negedge clk);
        ph = cyc % 12;
        exp_cpu = (ph == 11) || (eff_m[0] && (ph % 6) == 5);
        chk(eff_m[0] ? "R2 cpu fast" : "R1 cpu std", 32'(cpu_cyc_en), 32'(exp_cpu));
        for (int i = 0; i < NP; i++) begin
            // R3: periph i is governed by register bit i+1
            exp_p[i] = (ph == 11) || (eff_m[0] && !eff_m[i+1] && (ph % 6) == 5);
        end
        chk(eff_m[0] ? "R5 periph x2 (R8 boundary)" : "R4 periph std (R8 boundary)",
            32'(periph_tick_en), 32'(exp_p));
        if (ph == 11) chk("R9 all enables at phase 11", 32'({cpu_cyc_en, periph_tick_en}), 32'h7F);
        chk(sfr_addr == 8'h8F ? "R6 readback (R7 bit7)" : "R6 off-address read",
            32'(sfr_rd_data), sfr_addr == 8'h8F ? 32'(reg_m) : 32'h0);
        if (ph == 11) eff_m = reg_m[6:0];
        if (wr && addr == 8'h8F) reg_m = {1'b0, data[6:0]};
        sfr_wr    = wr;
        sfr_addr  = addr;
        sfr_wdata = data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        sfr_addr = 8'h8F;
        repeat (3) @(negedge clk);
        chk("R1 reset cpu enable", 32'(cpu_cyc_en), 32'h0);
        chk("R1 reset readback", 32'(sfr_rd_data), 32'h0);
        rst_n = 1'b1;
        for (int k = 0; k < 14; k++) step(1'b0, 8'h8F, 8'h00);
        for (int v = 0; v < 256; v++) begin
            step(1'b1, 8'h8F, 8'(v));
            for (int k = 0; k < 14; k++) step(1'b0, 8'h8F, 8'h00);
            step(1'b1, 8'h8E, ~8'(v));      // R6: off-address write ignored
            step(1'b0, 8'h8E, 8'h00);
            for (int k = 0; k < 14; k++) step(1'b0, 8'h8F, 8'h00);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule